// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block sits behind the bit-level front end of a two-wire serial EEPROM. It runs the memory commands on a 256-byte array. The front end reports bus events to it: start, stop, each received byte, and the master's acknowledge after each byte the device sends. The sequencer reads the select byte, the word address and the data bytes out of those events. It tracks the internal address counter and gathers write data in a 16-entry page buffer. It also presents the byte at the current read address to the front end for shifting out.

A write command gathers data but changes nothing on its own. Only a stop condition that ends the data phase raises a one-cycle commit request. That request carries the page base, all 16 buffered bytes and a mask of the bytes that were loaded. The protection/write-cycle controller answers in that same cycle with an allow signal, and the array takes the masked bytes only when allow is high. A repeated start or a plain abandonment throws the buffer away. The bus devices share one address counter, and a current read uses it in two ways. After a read it moves on to the next address. After a write it stays on the last address that was addressed.

Top module: `ee_cmd_seq`

## Requirements
- R1: After reset every array location reads FFh, the read pointer is address 00h, and `commit_req` is low.
- R2: The first byte after a start is the select byte. Its bit 0 set means read and clear means write. A write select takes one word-address byte and then data bytes. Bytes that arrive with no start before them are ignored.
- R3: A commit request is raised only by a stop condition during the data phase of a write. If a start ends the command instead, no request is raised and the array is left unchanged.
- R4: Data byte k of a write goes to the word address with its low four bits advanced by k, taken modulo 16. The upper four bits stay fixed, and `commit_base` holds them with the low nibble at zero.
- R5: More than 16 data bytes wrap within the page. The later bytes replace the earlier ones at the same offset.
- R6: `commit_mask` bit i is set exactly when offset i was loaded by the command. The byte for offset i is carried on `commit_data[8i+7:8i]`.
- R7: `commit_req` is high for exactly the one cycle after the stop. The array takes the masked bytes only when `commit_allow` is high in that cycle.
- R8: A read select after a read command starts at the last read address plus one. After a write command it starts at the last data address, or at the word address if no data followed.
- R9: A random read is a write select and word address, then a repeated start and a read select. It returns the byte at that word address on `rd_data` one cycle after the select byte.
- R10: A low master acknowledge advances the read address by one and wraps from FFh to 00h. A high acknowledge ends the read, and later acknowledges are ignored until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_evt | input | 1 | Start condition seen (one-cycle pulse) |
| stop_evt | input | 1 | Stop condition seen (one-cycle pulse) |
| byte_vld | input | 1 | A received byte is on `byte_data` |
| byte_data | input | 8 | Received byte |
| ack_vld | input | 1 | Master acknowledge slot after a sent byte |
| ack_high | input | 1 | Acknowledge level: 1 = not acknowledged |
| commit_allow | input | 1 | Protection/write-cycle controller grants the commit |
| rd_data | output | 8 | Byte at the current read address |
| commit_req | output | 1 | One-cycle commit request |
| commit_base | output | 8 | Page base address of the commit |
| commit_data | output | 128 | Sixteen buffered bytes, offset i at bits 8i+7:8i |
| commit_mask | output | 16 | Loaded-offset mask |

## Verification
The hardest state to reach is the address counter after a mixed history. Examples are a write that a repeated start abandoned, and a read that crossed FFh and was then ended by a high acknowledge. Both conditions come only from specific orderings of events. The stimulus chains whole commands together: a page write that overruns its page, a write cut off by a restart, a commit refused by the allow input, and a random read started at FEh and walked through the wrap. A behavioural model follows the counter, the buffer and the array, and every clock compares the read byte and the commit outputs against it.

// File: rtl/eeseq_pkg.sv
package eeseq_pkg;
    localparam int unsigned EE_ADDR_W   = 8;
    localparam int unsigned EE_DATA_W   = 8;
    localparam int unsigned EE_PAGE_LEN = 16;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SELECT,
        PH_WORD,
        PH_LOAD,
        PH_SEND,
        PH_DRAIN
    } phase_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic byte_vld;
        logic ack_vld;
        logic ack_high;
    } evt_t;

    function automatic logic sel_is_read(input logic [EE_DATA_W-1:0] sel);
        return sel[0];
    endfunction
endpackage

// File: rtl/eeseq_ctrl.sv
module eeseq_ctrl
    import eeseq_pkg::*;
#(
    parameter int unsigned AW   = EE_ADDR_W,
    parameter int unsigned DW   = EE_DATA_W,
    parameter int unsigned PAGE = EE_PAGE_LEN
) (
    input  logic                      clk,
    input  logic                      rst,
    input  evt_t                      ev,
    input  logic [DW-1:0]             byte_data,
    input  logic                      any_loaded,
    output logic                      buf_wr,
    output logic [$clog2(PAGE)-1:0]   buf_off,
    output logic                      commit_req,
    output logic [AW-1:0]             commit_base,
    output logic [AW-1:0]             rd_ptr
);
    localparam int unsigned OFFW = $clog2(PAGE);

    phase_t        phase;
    logic [AW-1:0] cursor;
    logic [AW-1:0] last_addr;
    logic [AW-1:0] rd_ptr_q;
    logic          was_read;
    logic          commit_q;
    logic [AW-1:0] open_addr;
    logic [AW-1:0] next_cursor;

    assign open_addr   = was_read ? last_addr + 1'b1 : last_addr;
    assign next_cursor = {cursor[AW-1:OFFW], cursor[OFFW-1:0] + 1'b1};
    assign buf_wr      = (phase == PH_LOAD) && ev.byte_vld && !ev.start && !ev.stop;
    assign buf_off     = cursor[OFFW-1:0];
    assign commit_base = {cursor[AW-1:OFFW], {OFFW{1'b0}}};
    assign commit_req  = commit_q;
    assign rd_ptr      = rd_ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cursor    <= '0;
            last_addr <= '0;
            rd_ptr_q  <= '0;
            was_read  <= 1'b0;
            commit_q  <= 1'b0;
        end else begin
            commit_q <= 1'b0;
            if (ev.stop) begin
                if (phase == PH_LOAD && any_loaded) begin
                    commit_q <= 1'b1;
                end
                phase <= PH_IDLE;
            end else if (ev.start) begin
                phase <= PH_SELECT;
            end else begin
                case (phase)
                    PH_SELECT: if (ev.byte_vld) begin
                        if (sel_is_read(byte_data)) begin
                            phase     <= PH_SEND;
                            last_addr <= open_addr;
                            rd_ptr_q  <= open_addr;
                            was_read  <= 1'b1;
                        end else begin
                            phase <= PH_WORD;
                        end
                    end
                    PH_WORD: if (ev.byte_vld) begin
                        cursor    <= AW'(byte_data);
                        last_addr <= AW'(byte_data);
                        was_read  <= 1'b0;
                        phase     <= PH_LOAD;
                    end
                    PH_LOAD: if (ev.byte_vld) begin
                        last_addr <= cursor;
                        cursor    <= next_cursor;
                    end
                    PH_SEND: if (ev.ack_vld) begin
                        if (ev.ack_high) begin
                            phase <= PH_DRAIN;
                        end else begin
                            last_addr <= last_addr + 1'b1;
                            rd_ptr_q  <= last_addr + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        commit_q |-> $past(ev.stop)) else $error("commit without stop"); // R3

    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOAD && $past(phase) == PH_LOAD) |->
            cursor[AW-1:OFFW] == $past(cursor[AW-1:OFFW])) else $error("page moved"); // R4

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SEND && $past(phase) == PH_SEND && rd_ptr_q != $past(rd_ptr_q)) |->
            rd_ptr_q == $past(rd_ptr_q) + 1'b1) else $error("read step"); // R10
endmodule

// File: rtl/eeseq_pagebuf.sv
module eeseq_pagebuf
    import eeseq_pkg::*;
#(
    parameter int unsigned DW   = EE_DATA_W,
    parameter int unsigned PAGE = EE_PAGE_LEN
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr,
    input  logic [$clog2(PAGE)-1:0]  off,
    input  logic [DW-1:0]            wdata,
    input  logic                     clr,
    output logic [PAGE-1:0]          mask,
    output logic [PAGE*DW-1:0]       data_flat
);
    localparam int unsigned OFFW = $clog2(PAGE);

    logic [PAGE-1:0] mask_q;
    assign mask = mask_q;

    for (genvar g = 0; g < PAGE; g++) begin : g_lane
        logic [DW-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q <= '0;
            end else if (wr && off == OFFW'(g)) begin
                lane_q <= wdata;
            end
        end
        assign data_flat[g*DW +: DW] = lane_q;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            mask_q <= '0;
        end else if (wr) begin
            mask_q[off] <= 1'b1;
        end
    end

    AST_LOAD_MARKS: assert property (@(posedge clk) disable iff (rst)
        ($past(wr) && !$past(clr)) |-> mask_q[$past(off)]) else $error("lane not marked"); // R6
endmodule

// File: rtl/eeseq_store.sv
module eeseq_store
    import eeseq_pkg::*;
#(
    parameter int unsigned AW   = EE_ADDR_W,
    parameter int unsigned DW   = EE_DATA_W,
    parameter int unsigned PAGE = EE_PAGE_LEN
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 commit,
    input  logic [AW-1:0]        base,
    input  logic [PAGE-1:0]      mask,
    input  logic [PAGE*DW-1:0]   data_flat,
    input  logic [AW-1:0]        rd_addr,
    output logic [DW-1:0]        rd_data
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (commit) begin
            for (int i = 0; i < PAGE; i++) begin
                if (mask[i]) begin
                    mem[base + AW'(i)] <= data_flat[i*DW +: DW];
                end
            end
        end
    end

    assign rd_data = mem[rd_addr];

    AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (!$past(commit) && $stable(rd_addr)) |-> $stable(rd_data)) else $error("array changed"); // R7
endmodule

// File: rtl/ee_cmd_seq.sv
module ee_cmd_seq
    import eeseq_pkg::*;
#(
    parameter int unsigned AW   = EE_ADDR_W,
    parameter int unsigned DW   = EE_DATA_W,
    parameter int unsigned PAGE = EE_PAGE_LEN
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_evt,
    input  logic                stop_evt,
    input  logic                byte_vld,
    input  logic [DW-1:0]       byte_data,
    input  logic                ack_vld,
    input  logic                ack_high,
    input  logic                commit_allow,
    output logic [DW-1:0]       rd_data,
    output logic                commit_req,
    output logic [AW-1:0]       commit_base,
    output logic [PAGE*DW-1:0]  commit_data,
    output logic [PAGE-1:0]     commit_mask
);
    localparam int unsigned OFFW = $clog2(PAGE);

    evt_t            ev;
    logic            buf_wr;
    logic [OFFW-1:0] buf_off;
    logic [AW-1:0]   rd_ptr;

    assign ev = '{start: start_evt, stop: stop_evt, byte_vld: byte_vld,
                  ack_vld: ack_vld, ack_high: ack_high};

    eeseq_ctrl #(.AW(AW), .DW(DW), .PAGE(PAGE)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .byte_data   (byte_data),
        .any_loaded  (|commit_mask),
        .buf_wr      (buf_wr),
        .buf_off     (buf_off),
        .commit_req  (commit_req),
        .commit_base (commit_base),
        .rd_ptr      (rd_ptr)
    );

    eeseq_pagebuf #(.DW(DW), .PAGE(PAGE)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .wr        (buf_wr),
        .off       (buf_off),
        .wdata     (byte_data),
        .clr       (start_evt | commit_req),
        .mask      (commit_mask),
        .data_flat (commit_data)
    );

    eeseq_store #(.AW(AW), .DW(DW), .PAGE(PAGE)) u_store (
        .clk       (clk),
        .rst       (rst),
        .commit    (commit_req & commit_allow),
        .base      (commit_base),
        .mask      (commit_mask),
        .data_flat (commit_data),
        .rd_addr   (rd_ptr),
        .rd_data   (rd_data)
    );

    AST_COMMIT_LOADED: assert property (@(posedge clk) disable iff (rst)
        commit_req |-> commit_mask != '0) else $error("empty commit"); // R6
endmodule

// File: tb/ee_cmd_seq_test.sv
module ee_cmd_seq_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_evt = 1'b0, stop_evt = 1'b0, byte_vld = 1'b0;
    logic [7:0]   byte_data = '0;
    logic         ack_vld = 1'b0, ack_high = 1'b0, commit_allow = 1'b1;
    logic [7:0]   rd_data;
    logic         commit_req;
    logic [7:0]   commit_base;
    logic [127:0] commit_data;
    logic [15:0]  commit_mask;

    always #4 clk = ~clk;

    ee_cmd_seq uut (
        .clk(clk), .rst(rst), .start_evt(start_evt), .stop_evt(stop_evt),
        .byte_vld(byte_vld), .byte_data(byte_data), .ack_vld(ack_vld),
        .ack_high(ack_high), .commit_allow(commit_allow), .rd_data(rd_data),
        .commit_req(commit_req), .commit_base(commit_base),
        .commit_data(commit_data), .commit_mask(commit_mask)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string cur_req = "R1";

    // behavioural model
    int ref_mem [256];
    int ref_buf [16];
    bit ref_mask [16];
    int ph = 0;       // 0 idle,1 select,2 word,3 load,4 send,5 drain
    int last = 0;
    bit wasrd = 0;
    int cur = 0;
    int ptr = 0;
    bit exp_commit = 0;

    task automatic model_edge();
        bit nc;
        bit anym;
        int a;
        nc = 0;
        if (rst) begin
            foreach (ref_mem[i]) ref_mem[i] = 255;
            foreach (ref_mask[i]) ref_mask[i] = 0;
            ph = 0; last = 0; wasrd = 0; cur = 0; ptr = 0; exp_commit = 0;
            return;
        end
        if (exp_commit && commit_allow) begin
            for (int i = 0; i < 16; i++)
                if (ref_mask[i]) ref_mem[(cur & 'hF0) + i] = ref_buf[i];
        end
        anym = 0;
        foreach (ref_mask[i]) if (ref_mask[i]) anym = 1;
        if (stop_evt) begin
            if (ph == 3 && anym) nc = 1;
            ph = 0;
        end else if (start_evt) begin
            ph = 1;
        end else begin
            case (ph)
                1: if (byte_vld) begin
                    if (byte_data[0]) begin
                        a = wasrd ? (last + 1) % 256 : last;
                        last = a; ptr = a; wasrd = 1; ph = 4;
                    end else ph = 2;
                end
                2: if (byte_vld) begin
                    cur = byte_data; last = cur; wasrd = 0; ph = 3;
                end
                3: if (byte_vld) begin
                    ref_buf[cur % 16] = byte_data;
                    ref_mask[cur % 16] = 1;
                    last = cur;
                    cur = (cur & 'hF0) | ((cur + 1) & 'hF);
                end
                4: if (ack_vld) begin
                    if (ack_high) ph = 5;
                    else begin last = (last + 1) % 256; ptr = last; end
                end
                default: ;
            endcase
        end
        if (start_evt || exp_commit) foreach (ref_mask[i]) ref_mask[i] = 0;
        exp_commit = nc;
    endtask

    task automatic fail_line(string tag, string what, logic [127:0] act, logic [127:0] exp);
        n_bad++;
        $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    endtask

    task automatic compare();
        logic [15:0] em;
        n_vec++;
        if (rd_data !== 8'(ref_mem[ptr])) fail_line(cur_req, "rd_data", 128'(rd_data), 128'(ref_mem[ptr]));
        n_vec++;
        if (commit_req !== exp_commit) fail_line(cur_req, "commit_req", 128'(commit_req), 128'(exp_commit));
        if (exp_commit) begin
            for (int i = 0; i < 16; i++) em[i] = ref_mask[i];
            n_vec++;
            if (commit_mask !== em) fail_line(cur_req, "commit_mask", 128'(commit_mask), 128'(em));
            n_vec++;
            if (commit_base !== 8'(cur & 'hF0)) fail_line(cur_req, "commit_base", 128'(commit_base), 128'(cur & 'hF0));
            for (int i = 0; i < 16; i++) if (ref_mask[i]) begin
                n_vec++;
                if (commit_data[i*8 +: 8] !== 8'(ref_buf[i]))
                    fail_line(cur_req, "commit_data lane", 128'(commit_data[i*8 +: 8]), 128'(ref_buf[i]));
            end
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask
    task automatic ev_start();
        start_evt = 1; cyc(); start_evt = 0;
    endtask
    task automatic ev_stop();
        stop_evt = 1; cyc(); stop_evt = 0;
    endtask
    task automatic ev_byte(logic [7:0] d);
        byte_vld = 1; byte_data = d; cyc(); byte_vld = 0;
    endtask
    task automatic ev_ack(logic h);
        ack_vld = 1; ack_high = h; cyc(); ack_vld = 0; ack_high = 0;
    endtask
    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_vec++;
        if (act !== exp) fail_line(tag, "value", 128'(act), 128'(exp));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        idle(3);
        rst = 0;
        // R1: reset state
        cur_req = "R1";
        idle(2);
        chk("R1", 16'(rd_data), 16'hFF);
        chk("R1", 16'(commit_req), 16'h0);

        // R2, R4, R6: byte write at 35h
        cur_req = "R2";
        ev_start(); ev_byte(8'hA0); ev_byte(8'h35); ev_byte(8'h5A); ev_stop();
        chk("R6", commit_mask, 16'h0020);
        chk("R4", 16'(commit_base), 16'h0030);
        chk("R7", 16'(commit_req), 16'h1);
        idle(2);

        // R8: current read after write returns last written address
        cur_req = "R8";
        ev_start(); ev_byte(8'hA1);
        chk("R8", 16'(rd_data), 16'h5A);
        ev_ack(1); ev_stop(); idle(1);

        // R4: page write wrapping inside page 70h
        cur_req = "R4";
        ev_start(); ev_byte(8'hA0); ev_byte(8'h7E);
        ev_byte(8'h11); ev_byte(8'h22); ev_byte(8'h33); ev_stop();
        chk("R4", commit_mask, 16'hC001);
        chk("R4", 16'(commit_base), 16'h0070);
        idle(2);

        // R5: 18 bytes into page 00h
        cur_req = "R5";
        ev_start(); ev_byte(8'hA0); ev_byte(8'h00);
        for (int k = 0; k < 18; k++) ev_byte(8'(8'h80 + k));
        ev_stop();
        chk("R5", commit_mask, 16'hFFFF);
        chk("R5", 16'(commit_data[7:0]), 16'h0090);
        chk("R5", 16'(commit_data[15:8]), 16'h0091);
        chk("R5", 16'(commit_data[23:16]), 16'h0082);
        idle(2);

        // R3: write abandoned by repeated start
        cur_req = "R3";
        ev_start(); ev_byte(8'hA0); ev_byte(8'h40); ev_byte(8'h99);
        ev_start();
        chk("R3", 16'(commit_req), 16'h0);
        ev_byte(8'hA1);
        chk("R3", 16'(rd_data), 16'hFF);
        ev_ack(1); ev_stop();
        chk("R3", 16'(commit_req), 16'h0);
        idle(1);

        // R7: commit refused by allow
        cur_req = "R7";
        commit_allow = 0;
        ev_start(); ev_byte(8'hA0); ev_byte(8'h50); ev_byte(8'h12); ev_stop();
        chk("R7", 16'(commit_req), 16'h1);
        idle(1);
        commit_allow = 1;
        idle(1);
        chk("R7", 16'(commit_req), 16'h0);
        ev_start(); ev_byte(8'hA0); ev_byte(8'h50); ev_start(); ev_byte(8'hA1);
        chk("R7", 16'(rd_data), 16'hFF);
        ev_ack(1); ev_stop(); idle(1);

        // R9: random read, then one sequential step
        cur_req = "R9";
        ev_start(); ev_byte(8'hA0); ev_byte(8'h7F); ev_start(); ev_byte(8'hA1);
        chk("R9", 16'(rd_data), 16'h22);
        ev_ack(0);
        chk("R9", 16'(rd_data), 16'hFF);
        ev_ack(1); ev_stop(); idle(1);

        // R8: current read after a read moves on by one
        cur_req = "R8";
        ev_start(); ev_byte(8'hA0); ev_byte(8'h7E); ev_start(); ev_byte(8'hA1);
        chk("R8", 16'(rd_data), 16'h11);
        ev_ack(1); ev_stop(); idle(1);
        ev_start(); ev_byte(8'hA1);
        chk("R8", 16'(rd_data), 16'h22);
        ev_ack(1); ev_stop(); idle(1);

        // R10: sequential read wrapping FFh -> 00h, then stop on high ack
        cur_req = "R10";
        ev_start(); ev_byte(8'hA0); ev_byte(8'hFE); ev_start(); ev_byte(8'hA1);
        chk("R10", 16'(rd_data), 16'hFF);
        ev_ack(0); ev_ack(0);
        chk("R10", 16'(rd_data), 16'h90);
        ev_ack(1);
        ev_ack(0);
        chk("R10", 16'(rd_data), 16'h90);
        ev_stop(); idle(1);

        // R2: byte without start is ignored
        cur_req = "R2";
        ev_byte(8'hA1);
        ev_ack(0);
        chk("R2", 16'(rd_data), 16'h90);
        idle(2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule